// File: doc/BRIEF.md
# Hash Message Block Formatter

This block sits between a word-wide write port and a hash compression core. Software or a DMA engine pushes the message as 32-bit words. The block applies the selected swap to each word and collects sixteen of them into a 512-bit block. It also keeps a running 64-bit count of the message length in bits. When the caller marks the final word and says how many of its bits are valid, the block completes the message without further input. It appends the single 1 marker bit, fills with zeros and places the length field. If the last block has no room for the length, it emits one more block.

The length field is big-endian for the SHA family and little-endian for MD5. The bit order used for partial final words follows the same split. On the way back, the block applies the same swap to digest words coming from the core. It presents only as many words as the chosen algorithm produces.

Top module: `hash_block_fmt`

## Requirements
- R1: After reset `in_ready_o` and `blk_valid_o` are 0. A `start_i` pulse latches `cfg_swap_i` and `cfg_alg_i`, clears the bit count and the word position, discards any half-built block, and raises `in_ready_o` on the next cycle. A word offered in the same cycle as `start_i` is dropped.
- R2: Each input word is transformed by `cfg_swap_i` before packing: 0 passes it unchanged, 1 exchanges the 16-bit halves, 2 reverses the byte order, and 3 reverses all 32 bits.
- R3: The k-th word of a block is placed at `blk_data_o[32k+31:32k]`. After 16 words that are not final, the block is offered with `blk_final_o` = 0.
- R4: While `blk_valid_o` is high, `in_ready_o` is low. If `blk_ready_i` is low, `blk_data_o` holds its value.
- R5: For the SHA algorithms (`cfg_alg_i` 0 = SHA-1, 1 = SHA-224, 2 = SHA-256), the valid bits of the final word are its top `in_nbits_i` bits. The marker 1 sits just below them and all lower bits are 0.
- R6: For MD5 (`cfg_alg_i` 3), the final word's bits are ordered byte 0 first (bits 7:0), each byte taken from its most significant bit down. Bits past the valid count are zero except for the marker at the next position.
- R7: The length equals 32 times the number of non-final words plus `in_nbits_i`. It fills words 14 and 15 of the final block. For SHA, word 14 holds the upper half and word 15 the lower half. For MD5 the halves are exchanged.
- R8: If the marker falls in word 14 or 15, or a full final word ends in word 13 or later, an extra block is emitted. It holds zeros and the length, and only it carries `blk_final_o` = 1.
- R9: When a full 32-bit final word lands in word 15, the extra block's word 0 is the marker word: 0x80000000 for SHA, 0x00000080 for MD5.
- R10: A digest read of index i returns `dig_word_i` transformed by the latched swap, one cycle later. `dig_valid_o` is 1 only if i is below the word count of the algorithm (5, 7, 8 or 4 for SHA-1, SHA-224, SHA-256, MD5). Otherwise the data is zero.
- R11: Once the final block is accepted, `in_ready_o` stays low until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new message |
| cfg_swap_i | input | 2 | Word swap mode, latched at start |
| cfg_alg_i | input | 2 | Algorithm select, latched at start |
| in_valid_i | input | 1 | Input word offered |
| in_ready_o | output | 1 | Input word can be taken |
| in_data_i | input | 32 | Input word |
| in_last_i | input | 1 | This word ends the message |
| in_nbits_i | input | 6 | Valid bits in the final word, 0 to 32 |
| blk_valid_o | output | 1 | Block offered to the core |
| blk_ready_i | input | 1 | Core takes the block |
| blk_data_o | output | 512 | Block, word k at bits 32k+31:32k |
| blk_final_o | output | 1 | Block is the last of the message |
| dig_rd_i | input | 1 | Digest word read strobe |
| dig_idx_i | input | 3 | Digest word index |
| dig_word_i | input | 32 | Raw digest word from the core |
| dig_data_o | output | 32 | Swapped digest word |
| dig_valid_o | output | 1 | Digest word is within the algorithm's length |

## Verification
A wrong word position shows up in the very next block the core takes, as a word in the wrong 32-bit slot. It also moves the padding, which changes the final block's content or the number of blocks. A wrong bit count or a lost start clear only shows up in the length words of the final block. So every directed message ends with a compare of the complete last block. A stuck handshake state shows within one cycle as `in_ready_o` and `blk_valid_o` both high, or as a final block after which input is still accepted.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 64;
  localparam int NB_W   = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {SW_NONE = 2'd0, SW_HALF = 2'd1, SW_BYTE = 2'd2, SW_BIT = 2'd3} swap_e;
  typedef enum logic [1:0] {ALG_SHA1 = 2'd0, ALG_SHA224 = 2'd1, ALG_SHA256 = 2'd2, ALG_MD5 = 2'd3} alg_e;

  function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [WORD_W-1:0] swap_word(input logic [WORD_W-1:0] w, input swap_e m);
    logic [WORD_W-1:0] r;
    case (m)
      SW_HALF: r = {w[15:0], w[31:16]};
      SW_BYTE: r = byte_rev(w);
      SW_BIT:  for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
      default: r = w;
    endcase
    return r;
  endfunction

  // length words for slots 14 and 15 of the closing block
  function automatic logic [WORD_W-1:0] len_slot(input logic [LEN_W-1:0] l, input logic md5, input logic second);
    return (md5 ^ second) ? l[WORD_W-1:0] : l[LEN_W-1:WORD_W];
  endfunction
endpackage

// File: rtl/hbf_word_prep.sv
module hbf_word_prep
  import hbf_pkg::*;
(
  input  logic [WORD_W-1:0] raw_i,
  input  swap_e             mode_i,
  input  logic              md5_i,
  input  logic [NB_W-1:0]   nbits_i,
  output logic [WORD_W-1:0] body_o,
  output logic [WORD_W-1:0] tail_o,
  output logic [WORD_W-1:0] marker_o
);
  logic [WORD_W-1:0] view, keep_mask, mark_bit, tail_view;
  logic              full;

  assign full = (nbits_i >= NB_W'(WORD_W));
  assign body_o = swap_word(raw_i, mode_i);
  // bring MD5 byte order into a msb-first stream view
  assign view = md5_i ? byte_rev(body_o) : body_o;

  always_comb begin
    keep_mask = '0;
    mark_bit  = '0;
    for (int k = 0; k < WORD_W; k++) begin
      keep_mask[WORD_W-1-k] = (NB_W'(k) < nbits_i);
      mark_bit[WORD_W-1-k]  = (NB_W'(k) == nbits_i);
    end
  end

  assign tail_view = (view & keep_mask) | mark_bit;
  assign tail_o    = md5_i ? byte_rev(tail_view) : tail_view;
  assign marker_o  = md5_i ? 32'h0000_0080 : 32'h8000_0000;

  always_comb begin
    p_one_marker_r5: assert ($countones(tail_view & ~keep_mask) == (full ? 0 : 1))
      else $error("marker count wrong");
  end
endmodule

// File: rtl/hbf_len_ctr.sv
module hbf_len_ctr
  import hbf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             add_en_i,
  input  logic [NB_W-1:0]  add_val_i,
  output logic [LEN_W-1:0] len_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) len_o <= '0;
    else if (add_en_i) len_o <= len_o + LEN_W'(add_val_i);
  end

  p_len_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !add_en_i) |=> $stable(len_o));
endmodule

// File: rtl/hbf_digest_out.sv
module hbf_digest_out
  import hbf_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  alg_e              alg_i,
  input  swap_e             mode_i,
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o
);
  logic [IDX_W:0] n_words;
  logic           in_range;

  always_comb begin
    case (alg_i)
      ALG_SHA1:   n_words = (IDX_W+1)'(5);
      ALG_SHA224: n_words = (IDX_W+1)'(7);
      ALG_SHA256: n_words = (IDX_W+1)'(8);
      default:    n_words = (IDX_W+1)'(4);
    endcase
  end

  assign in_range = ({1'b0, idx_i} < n_words);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= rd_i && in_range;
      data_o  <= (rd_i && in_range) ? swap_word(word_i, mode_i) : '0;
    end
  end

  p_dig_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(rd_i));
  p_dig_md5_span_r10: assert property (@(posedge clk) disable iff (rst)
    (valid_o && alg_i == ALG_MD5 && $stable(alg_i)) |-> ($past(idx_i) < IDX_W'(4)));
endmodule

// File: rtl/hash_block_fmt.sv
module hash_block_fmt
  import hbf_pkg::*;
#(
  parameter int BLK_WORDS = 16,
  parameter int DIG_IDX_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [1:0]               cfg_swap_i,
  input  logic [1:0]               cfg_alg_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [31:0]              in_data_i,
  input  logic                     in_last_i,
  input  logic [5:0]               in_nbits_i,
  output logic                     blk_valid_o,
  input  logic                     blk_ready_i,
  output logic [BLK_WORDS*32-1:0]  blk_data_o,
  output logic                     blk_final_o,
  input  logic                     dig_rd_i,
  input  logic [DIG_IDX_W-1:0]     dig_idx_i,
  input  logic [31:0]              dig_word_i,
  output logic [31:0]              dig_data_o,
  output logic                     dig_valid_o
);
  localparam int IDX_W   = $clog2(BLK_WORDS);
  localparam int SLOT_HI = BLK_WORDS - 2;
  localparam int SLOT_LO = BLK_WORDS - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_SEND} st_e;

  st_e               state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              final_q, extra_q, extra_mark_q;
  swap_e             mode_q;
  alg_e              alg_q;
  logic              md5;
  logic [WORD_W-1:0] words_q [BLK_WORDS];
  logic [WORD_W-1:0] body_w, tail_w, marker_w;
  logic [LEN_W-1:0]  len_q, len_fin;
  logic              take, take_body, take_tail, full, fits, send_extra;
  logic [NB_W-1:0]   add_val;

  assign md5  = (alg_q == ALG_MD5);
  assign full = (in_nbits_i >= NB_W'(WORD_W));
  assign fits = full ? (idx_q <= IDX_W'(BLK_WORDS-4)) : (idx_q <= IDX_W'(BLK_WORDS-3));

  assign take       = !start_i && (state_q == ST_FILL) && in_valid_i;
  assign take_body  = take && !in_last_i;
  assign take_tail  = take && in_last_i;
  assign send_extra = !start_i && (state_q == ST_SEND) && blk_ready_i && extra_q;

  assign add_val = (!in_last_i || full) ? NB_W'(WORD_W) : in_nbits_i;
  assign len_fin = len_q + LEN_W'(in_nbits_i);

  hbf_word_prep u_prep (
    .raw_i(in_data_i), .mode_i(mode_q), .md5_i(md5), .nbits_i(in_nbits_i),
    .body_o(body_w), .tail_o(tail_w), .marker_o(marker_w)
  );

  hbf_len_ctr u_len (
    .clk(clk), .rst(rst), .clr_i(start_i), .add_en_i(take),
    .add_val_i(add_val), .len_o(len_q)
  );

  hbf_digest_out #(.IDX_W(DIG_IDX_W)) u_dig (
    .clk(clk), .rst(rst), .alg_i(alg_q), .mode_i(mode_q), .rd_i(dig_rd_i),
    .idx_i(dig_idx_i), .word_i(dig_word_i), .data_o(dig_data_o), .valid_o(dig_valid_o)
  );

  // per-slot write port: body word, closing word, fill, length or extra block
  for (genvar j = 0; j < BLK_WORDS; j++) begin : g_slot
    logic              wr;
    logic [WORD_W-1:0] wd;
    always_comb begin
      wr = 1'b0;
      wd = '0;
      if (take_body) begin
        wr = (idx_q == IDX_W'(j));
        wd = body_w;
      end else if (take_tail) begin
        if (idx_q == IDX_W'(j)) begin
          wr = 1'b1;
          wd = tail_w;
        end else if (IDX_W'(j) > idx_q) begin
          wr = 1'b1;
          if (full && ({1'b0, idx_q} + 1'b1) == (IDX_W+1)'(j)) wd = marker_w;
          else if (fits && j == SLOT_HI) wd = len_slot(len_fin, md5, 1'b0);
          else if (fits && j == SLOT_LO) wd = len_slot(len_fin, md5, 1'b1);
        end
      end else if (send_extra) begin
        wr = 1'b1;
        if (j == 0 && extra_mark_q) wd = marker_w;
        else if (j == SLOT_HI)      wd = len_slot(len_q, md5, 1'b0);
        else if (j == SLOT_LO)      wd = len_slot(len_q, md5, 1'b1);
      end
    end
    always_ff @(posedge clk) begin
      if (wr) words_q[j] <= wd;
    end
    assign blk_data_o[32*j +: 32] = words_q[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      final_q      <= 1'b0;
      extra_q      <= 1'b0;
      extra_mark_q <= 1'b0;
      mode_q       <= SW_NONE;
      alg_q        <= ALG_SHA1;
    end else if (start_i) begin
      state_q      <= ST_FILL;
      idx_q        <= '0;
      final_q      <= 1'b0;
      extra_q      <= 1'b0;
      extra_mark_q <= 1'b0;
      mode_q       <= swap_e'(cfg_swap_i);
      alg_q        <= alg_e'(cfg_alg_i);
    end else begin
      case (state_q)
        ST_FILL: begin
          if (take_body) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_W'(BLK_WORDS-1)) begin
              state_q <= ST_SEND;
              final_q <= 1'b0;
            end
          end else if (take_tail) begin
            idx_q        <= '0;
            state_q      <= ST_SEND;
            final_q      <= fits;
            extra_q      <= !fits;
            extra_mark_q <= full && (idx_q == IDX_W'(BLK_WORDS-1));
          end
        end
        ST_SEND: begin
          if (blk_ready_i) begin
            if (extra_q) begin
              extra_q      <= 1'b0;
              extra_mark_q <= 1'b0;
              final_q      <= 1'b1;
            end else begin
              state_q <= final_q ? ST_IDLE : ST_FILL;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign in_ready_o  = (state_q == ST_FILL);
  assign blk_valid_o = (state_q == ST_SEND);
  assign blk_final_o = (state_q == ST_SEND) && final_q;

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (blk_valid_o && !blk_ready_i && !start_i) |=> (blk_valid_o && $stable(blk_data_o)));
  p_extra_next_r8: assert property (@(posedge clk) disable iff (rst)
    (blk_valid_o && blk_ready_i && extra_q && !start_i) |=> (blk_valid_o && blk_final_o));
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (blk_valid_o && blk_ready_i && blk_final_o && !start_i) |=> (!in_ready_o && !blk_valid_o));
  p_start_ready_r1: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (in_ready_o && !blk_valid_o));
endmodule

// File: tb/hash_block_fmt_bench.sv
`timescale 1ns/1ps
module hash_block_fmt_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [1:0]   cfg_swap_i = 2'd0, cfg_alg_i = 2'd0;
  logic         in_valid_i = 1'b0, in_last_i = 1'b0;
  logic         in_ready_o;
  logic [31:0]  in_data_i = '0;
  logic [5:0]   in_nbits_i = '0;
  logic         blk_valid_o, blk_final_o;
  logic         blk_ready_i = 1'b0;
  logic [511:0] blk_data_o;
  logic         dig_rd_i = 1'b0;
  logic [2:0]   dig_idx_i = '0;
  logic [31:0]  dig_word_i = '0, dig_data_o;
  logic         dig_valid_o;

  always #2.5 clk = ~clk;

  hash_block_fmt u_hash_block_fmt (.*);

  int n_checks = 0, n_errs = 0;
  int stall = 0, ngot = 0, r4_bad = 0, hold_bad = 0;
  logic [511:0] got [4];
  logic         gfin [4];
  logic [31:0]  e [48];

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tsw(input logic [31:0] w, input logic [1:0] m);
    logic [31:0] r;
    case (m)
      2'd1: r = {w[15:0], w[31:16]};
      2'd2: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
      2'd3: for (int i = 0; i < 32; i++) r[i] = w[31-i];
      default: r = w;
    endcase
    return r;
  endfunction

  function automatic int bitpos(input int k, input bit md5);
    return md5 ? (8*(k/8) + 7 - (k%8)) : (31 - k);
  endfunction

  // block consumer with optional stall
  initial begin
    int wait_cnt = 0;
    logic [511:0] prev = '0;
    forever begin
      @(negedge clk);
      blk_ready_i = 1'b0;
      if (blk_valid_o) begin
        if (in_ready_o) r4_bad++;
        if (wait_cnt >= stall) begin
          if (ngot < 4) begin got[ngot] = blk_data_o; gfin[ngot] = blk_final_o; end
          ngot++;
          blk_ready_i = 1'b1;
          wait_cnt = 0;
        end else begin
          if (wait_cnt > 0 && blk_data_o != prev) hold_bad++;
          prev = blk_data_o;
          wait_cnt++;
        end
      end
    end
  end

  initial begin
    #(5ns * 150000);
    n_errs++; n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  task automatic pulse_start(input logic [1:0] sw, input logic [1:0] alg);
    @(negedge clk);
    cfg_swap_i = sw; cfg_alg_i = alg; start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  task automatic push(input logic [31:0] d, input bit last, input int nb);
    @(negedge clk);
    while (!in_ready_o) @(negedge clk);
    in_valid_i = 1'b1; in_data_i = d; in_last_i = last; in_nbits_i = 6'(nb);
    @(posedge clk); #1 in_valid_i = 1'b0; in_last_i = 1'b0;
  endtask

  task automatic run_msg(input string tag, input int nw, input int nb,
                         input logic [1:0] sw, input logic [1:0] alg, input int stl);
    bit md5 = (alg == 2'd3);
    int p, nblk;
    logic [31:0] d, v;
    logic [63:0] len;
    stall = stl; ngot = 0; r4_bad = 0; hold_bad = 0;
    for (int i = 0; i < 48; i++) e[i] = '0;
    pulse_start(sw, alg);
    for (int k = 0; k <= nw; k++) begin
      d = 32'h1357_9BDF ^ (k * 32'h0102_0A05) ^ {24'd0, 8'(nw)};
      if (k < nw) begin
        e[k] = tsw(d, sw);
        push(d, 1'b0, 32);
      end else begin
        v = tsw(d, sw);
        e[k] = '0;
        for (int b = 0; b < nb; b++) e[k][bitpos(b, md5)] = v[bitpos(b, md5)];
        if (nb < 32) e[k][bitpos(nb, md5)] = 1'b1;
        push(d, 1'b1, nb);
      end
    end
    p = nw + 1;
    if (nb == 32) begin e[p] = md5 ? 32'h80 : 32'h8000_0000; p++; end
    nblk = (p + 2 + 15) / 16;
    len = 64'(nw) * 32 + 64'(nb);
    e[16*nblk-2] = md5 ? len[31:0] : len[63:32];
    e[16*nblk-1] = md5 ? len[63:32] : len[31:0];
    for (int c = 0; c < 400 && ngot < nblk; c++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ngot == nblk, {tag, " R8 block count"}, 512'(ngot), 512'(nblk));
    for (int b = 0; b < nblk && b < 4; b++) begin
      logic [511:0] x;
      for (int j = 0; j < 16; j++) x[32*j +: 32] = e[16*b + j];
      chk(got[b] == x, {tag, " R3 R7 block content"}, got[b], x);
      chk(gfin[b] == (b == nblk-1), {tag, " R3 R8 final flag"}, 512'(gfin[b]), 512'(b == nblk-1));
    end
    chk(r4_bad == 0 && hold_bad == 0, "R4 ready low and data held while block waits",
        512'(r4_bad + hold_bad), 512'(0));
    chk(!in_ready_o, "R11 input closed after final block", 512'(in_ready_o), 512'(0));
  endtask

  task automatic test_reset;
    chk(!in_ready_o && !blk_valid_o && !dig_valid_o, "R1 reset state",
        512'({in_ready_o, blk_valid_o, dig_valid_o}), 512'(0));
  endtask

  task automatic test_restart;
    pulse_start(2'd0, 2'd2);
    chk(in_ready_o, "R1 ready after start", 512'(in_ready_o), 512'(1));
    for (int k = 0; k < 3; k++) push(32'hDEAD_0000 + k, 1'b0, 32);
    // r1_ restart discards the partial block and the count
    run_msg("R1 restart", 1, 16, 2'd0, 2'd2, 0);
  endtask

  task automatic test_digest(input logic [1:0] sw, input logic [1:0] alg, input int nwd);
    pulse_start(sw, alg);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w = 32'h8421_C3A5 + i * 32'h0101_1111;
      logic [31:0] ex = (i < nwd) ? tsw(w, sw) : 32'h0;
      @(negedge clk);
      dig_rd_i = 1'b1; dig_idx_i = 3'(i); dig_word_i = w;
      @(negedge clk);
      dig_rd_i = 1'b0;
      chk(dig_valid_o == (i < nwd) && dig_data_o == ex, "R10 digest word",
          {479'(0), dig_valid_o, dig_data_o}, {479'(0), 1'(i < nwd), ex});
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_msg("R5 sha256 short", 3, 8, 2'd0, 2'd2, 0);
    run_msg("R2 R3 sha1 half swap two blocks", 16, 20, 2'd1, 2'd0, 3);
    run_msg("R6 md5 byte swap", 5, 12, 2'd2, 2'd3, 1);
    run_msg("R2 R8 sha224 bit rev marker in 15", 14, 32, 2'd3, 2'd1, 2);
    run_msg("R9 md5 full word at 15", 15, 32, 2'd0, 2'd3, 0);
    run_msg("R5 R7 empty message", 0, 0, 2'd0, 2'd2, 0);
    run_msg("R5 fits at 13", 13, 31, 2'd0, 2'd0, 1);
    run_msg("R6 R8 md5 partial at 14", 14, 5, 2'd1, 2'd3, 0);
    test_restart();
    test_digest(2'd0, 2'd0, 5);
    test_digest(2'd1, 2'd1, 7);
    test_digest(2'd3, 2'd2, 8);
    test_digest(2'd2, 2'd3, 4);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule